// File: doc/BRIEF.md
# GMII Receive Deframer

This block sits behind an 8B/10B decoder on the receive side of a gigabit Ethernet path. Each clock it may take one decoded byte, marked by a flag that says whether the byte is a control code or plain data. It also takes a level that reports whether the link has reached frame synchronisation. From these it produces the three GMII receive signals: an 8-bit data bus, a data-valid strobe and an error strobe.

Packets are delimited by control codes. A start code opens a packet, and the cycle that carries it is shown as a preamble byte with the valid strobe high. Data bytes pass straight through. A terminate code closes the packet. Inside a packet, an error code, any other control code, or a missing input byte is marked with the error strobe, and the packet stays open. Outside a packet the valid and error strobes stay low. The data bus has fixed values in two cases: all zeros while reset is held, and all ones while synchronisation is missing.

The input is a stream with a valid qualifier and no ready. The block accepts a byte in every cycle where `in_valid` is high and never applies back-pressure. A cycle without a byte counts as a gap. All outputs are registered and show the result of an accepted byte one clock later.

Top module: `gmii_rx_deframer`

## Requirements
- R1: When `rst_n` is low at a rising edge (synchronous, active low), the next outputs are `rxd` = 0x00, `rxdv` = 0 and `rxer` = 0, and any open packet is closed.
- R2: When reset is inactive and `sync_ok` is low at a rising edge, the next outputs are `rxd` = 0xFF, `rxdv` = 0 and `rxer` = 0, and any open packet is abandoned.
- R3: When synchronised and no packet is open, any input other than a start code (a data byte, the idle code 0xBC, the terminate code 0xFD, the error code 0xFE, or `in_valid` low) gives `rxdv` = 0, `rxer` = 0 and `rxd` = 0x00 on the next cycle.
- R4: When synchronised and no packet is open, a byte 0xFB with `in_k` = 1 gives `rxdv` = 1, `rxer` = 0 and `rxd` = 0x55 on the next cycle, and opens a packet.
- R5: Inside a packet, a byte with `in_k` = 0 gives `rxdv` = 1, `rxer` = 0 and `rxd` equal to that byte on the next cycle.
- R6: Inside a packet, a byte 0xFD with `in_k` = 1 gives `rxdv` = 0, `rxer` = 0 and `rxd` = 0x00 on the next cycle, and closes the packet. A packet is therefore one contiguous `rxdv` pulse that covers the start cycle and the data.
- R7: Inside a packet, a byte 0xFE with `in_k` = 1 gives `rxdv` = 1, `rxer` = 1 and `rxd` = 0xFE on the next cycle, and the packet stays open.
- R8: Inside a packet, any other control code with `in_k` = 1 (including a repeated 0xFB and 0xBC) gives `rxdv` = 1, `rxer` = 1 and `rxd` equal to that byte, and the packet stays open.
- R9: Inside a packet, a cycle with `in_valid` = 0 gives `rxdv` = 1, `rxer` = 1 and `rxd` = 0x00 on the next cycle, and the packet stays open.
- R10: `rxer` is never high while `rxdv` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock (125 MHz in use) |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_ok | input | 1 | High while frame synchronisation is held |
| in_valid | input | 1 | A decoded byte is present this cycle |
| in_k | input | 1 | The decoded byte is a control code |
| in_byte | input | 8 | Decoded byte |
| rxd | output | 8 | GMII receive data |
| rxdv | output | 1 | GMII receive data valid |
| rxer | output | 1 | GMII receive error |

## Verification
Each result is due exactly one rising edge after the input that causes it, because every output comes from a single register stage. This holds for the data path, the reset values and the unsynchronised values. The bench changes inputs on the falling edge and computes the expected outputs for that input set from its own model of the packet state. It then compares them at the next falling edge, half a period after the edge that captured them. The comparison therefore never lands on the edge where the outputs change.

// File: rtl/gmii_rx_pkg.sv
package gmii_rx_pkg;

  typedef enum logic [2:0] {
    SYM_GAP,
    SYM_DATA,
    SYM_START,
    SYM_TERM,
    SYM_ERR,
    SYM_CTRL
  } sym_cls_t;

endpackage

// File: rtl/gmii_rx_classify.sv
module gmii_rx_classify
  import gmii_rx_pkg::*;
#(
  parameter int unsigned          W          = 8,
  parameter logic [W-1:0]         START_CODE = 8'hFB,
  parameter logic [W-1:0]         TERM_CODE  = 8'hFD,
  parameter logic [W-1:0]         ERR_CODE   = 8'hFE
) (
  input  logic         sym_valid,
  input  logic         sym_k,
  input  logic [W-1:0] sym_byte,
  output sym_cls_t     sym_cls
);

  always_comb begin
    if (!sym_valid)                   sym_cls = SYM_GAP;
    else if (!sym_k)                  sym_cls = SYM_DATA;
    else if (sym_byte == START_CODE)  sym_cls = SYM_START;
    else if (sym_byte == TERM_CODE)   sym_cls = SYM_TERM;
    else if (sym_byte == ERR_CODE)    sym_cls = SYM_ERR;
    else                              sym_cls = SYM_CTRL;
  end

endmodule

// File: rtl/gmii_rx_track.sv
module gmii_rx_track
  import gmii_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sync_ok,
  input  sym_cls_t sym_cls,
  output logic     in_pkt_q
);

  logic in_pkt_d;

  always_comb begin
    in_pkt_d = in_pkt_q;
    if (!sync_ok)                            in_pkt_d = 1'b0;
    else if (!in_pkt_q && sym_cls == SYM_START) in_pkt_d = 1'b1;
    else if (in_pkt_q && sym_cls == SYM_TERM)   in_pkt_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt_q <= 1'b0;
    else        in_pkt_q <= in_pkt_d;
  end

  // R6
  term_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && in_pkt_q && sym_cls == SYM_TERM) |=> !in_pkt_q);

  // R7
  err_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && in_pkt_q && sym_cls == SYM_ERR) |=> in_pkt_q);

endmodule

// File: rtl/gmii_rx_drive.sv
module gmii_rx_drive
  import gmii_rx_pkg::*;
#(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] PRE_BYTE  = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_ok,
  input  logic         in_pkt_q,
  input  sym_cls_t     sym_cls,
  input  logic [W-1:0] sym_byte,
  output logic [W-1:0] rxd_q,
  output logic         rxer_q
);

  localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZEROS = '0;

  logic [W-1:0] rxd_d;
  logic         rxer_d;

  always_comb begin
    rxd_d  = ALL_ZEROS;
    rxer_d = 1'b0;
    if (!sync_ok) begin
      rxd_d = ALL_ONES;
    end else if (!in_pkt_q) begin
      if (sym_cls == SYM_START) rxd_d = PRE_BYTE;
    end else begin
      unique case (sym_cls)
        SYM_DATA: rxd_d = sym_byte;
        SYM_TERM: rxd_d = ALL_ZEROS;
        SYM_GAP:  rxer_d = 1'b1;
        default: begin
          rxd_d  = sym_byte;
          rxer_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q  <= ALL_ZEROS;
      rxer_q <= 1'b0;
    end else begin
      rxd_q  <= rxd_d;
      rxer_q <= rxer_d;
    end
  end

  // R5
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && in_pkt_q && sym_cls == SYM_DATA) |=> (!rxer_q && rxd_q == $past(sym_byte)));

  // R9
  gap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && in_pkt_q && sym_cls == SYM_GAP) |=> (rxer_q && rxd_q == ALL_ZEROS));

endmodule

// File: rtl/gmii_rx_deframer.sv
module gmii_rx_deframer
  import gmii_rx_pkg::*;
#(
  parameter int unsigned  W          = 8,
  parameter logic [W-1:0] START_CODE = 8'hFB,
  parameter logic [W-1:0] TERM_CODE  = 8'hFD,
  parameter logic [W-1:0] ERR_CODE   = 8'hFE,
  parameter logic [W-1:0] PRE_BYTE   = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_ok,
  input  logic         in_valid,
  input  logic         in_k,
  input  logic [W-1:0] in_byte,
  output logic [W-1:0] rxd,
  output logic         rxdv,
  output logic         rxer
);

  sym_cls_t cls;
  logic     in_pkt_q;

  gmii_rx_classify #(
    .W(W), .START_CODE(START_CODE), .TERM_CODE(TERM_CODE), .ERR_CODE(ERR_CODE)
  ) u_cls (
    .sym_valid (in_valid),
    .sym_k     (in_k),
    .sym_byte  (in_byte),
    .sym_cls   (cls)
  );

  gmii_rx_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_ok  (sync_ok),
    .sym_cls  (cls),
    .in_pkt_q (in_pkt_q)
  );

  gmii_rx_drive #(.W(W), .PRE_BYTE(PRE_BYTE)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_ok  (sync_ok),
    .in_pkt_q (in_pkt_q),
    .sym_cls  (cls),
    .sym_byte (in_byte),
    .rxd_q    (rxd),
    .rxer_q   (rxer)
  );

  assign rxdv = in_pkt_q;

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;

  // R1
  always @(negedge clk) begin
    if (rst_seen_q === 1'b1) begin
      reset_zero_chk: assert (rxd == '0 && !rxdv && !rxer);
    end
  end

  // R2
  unsync_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> (rxd == {W{1'b1}} && !rxdv && !rxer));

  // R4
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && in_valid && in_k && in_byte == START_CODE && !rxdv) |=> (rxdv && !rxer && rxd == PRE_BYTE));

  // R10
  err_needs_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxer |-> rxdv);

endmodule

// File: tb/sim_gmii_rx_deframer.sv
module sim_gmii_rx_deframer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_ok = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_k = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] rxd;
  logic       rxdv, rxer;

  int checks = 0;
  int errors = 0;

  logic       m_pkt = 1'b0;
  logic [7:0] e_rxd;
  logic       e_dv, e_er;
  string      e_tag;

  always #10 clk = ~clk;

  gmii_rx_deframer u0 (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .in_valid(in_valid),
    .in_k(in_k), .in_byte(in_byte), .rxd(rxd), .rxdv(rxdv), .rxer(rxer)
  );

  // Reference model of the requirements: computes the outputs due after the next edge.
  function automatic void predict();
    e_rxd = 8'h00; e_dv = 1'b0; e_er = 1'b0;
    if (!rst_n) begin
      e_tag = "R1"; m_pkt = 1'b0;
    end else if (!sync_ok) begin
      e_tag = "R2"; e_rxd = 8'hFF; m_pkt = 1'b0;
    end else if (!m_pkt) begin
      if (in_valid && in_k && in_byte == 8'hFB) begin
        e_tag = "R4"; e_rxd = 8'h55; e_dv = 1'b1; m_pkt = 1'b1;
      end else e_tag = "R3";
    end else if (!in_valid) begin
      e_tag = "R9"; e_dv = 1'b1; e_er = 1'b1;
    end else if (!in_k) begin
      e_tag = "R5"; e_dv = 1'b1; e_rxd = in_byte;
    end else if (in_byte == 8'hFD) begin
      e_tag = "R6"; m_pkt = 1'b0;
    end else if (in_byte == 8'hFE) begin
      e_tag = "R7"; e_dv = 1'b1; e_er = 1'b1; e_rxd = in_byte;
    end else begin
      e_tag = "R8"; e_dv = 1'b1; e_er = 1'b1; e_rxd = in_byte;
    end
  endfunction

  // Inputs are already set on a falling edge; capture happens at the rising edge,
  // comparison happens at the following falling edge.
  task automatic cyc();
    predict();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rxd !== e_rxd || rxdv !== e_dv || rxer !== e_er) begin
      errors++;
      $display("FAIL %s: got rxd=%02h dv=%b er=%b, expected rxd=%02h dv=%b er=%b",
               e_tag, rxd, rxdv, rxer, e_rxd, e_dv, e_er);
    end
    // R10: error without valid never legal
    if (rxer === 1'b1 && rxdv !== 1'b1) begin
      errors++;
      $display("FAIL R10: got rxer=1 rxdv=%b, expected rxdv=1", rxdv);
    end
  endtask

  task automatic put(input logic v, input logic k, input logic [7:0] b);
    in_valid = v; in_k = k; in_byte = b;
    cyc();
  endtask

  task automatic rand_packet();
    int len;
    int r;
    for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
      r = int'($urandom_range(0, 5));
      if (r == 0)      put(1'b0, 1'b0, 8'h00);
      else if (r == 1) put(1'b1, 1'b0, 8'($urandom));
      else if (r == 2) put(1'b1, 1'b1, 8'hFE);
      else             put(1'b1, 1'b1, 8'hBC);
    end
    put(1'b1, 1'b1, 8'hFB);
    len = int'($urandom_range(1, 24));
    for (int i = 0; i < len; i++) begin
      r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 299) == 0) sync_ok = 1'b0;
      if ($urandom_range(0, 399) == 0) rst_n = 1'b0;
      if (r < 4)       put(1'b1, 1'b1, 8'hFE);
      else if (r < 7)  put(1'b1, 1'b1, 8'hBC);
      else if (r < 10) put(1'b0, 1'b0, 8'($urandom));
      else             put(1'b1, 1'b0, 8'($urandom));
      sync_ok = 1'b1;
      rst_n = 1'b1;
    end
    put(1'b1, 1'b1, 8'hFD);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: reset values, even with sync and a start code present
    sync_ok = 1'b1;
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b1, 8'hFB);
    rst_n = 1'b1;
    // R2: unsynchronised gives all ones, start code ignored
    sync_ok = 1'b0;
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b0, 8'hA5);
    sync_ok = 1'b1;
    // R3: idle, stray terminate, stray error, gap, data outside packet
    put(1'b1, 1'b1, 8'hBC);
    put(1'b1, 1'b1, 8'hFD);
    put(1'b1, 1'b1, 8'hFE);
    put(1'b0, 1'b1, 8'hFB);
    put(1'b1, 1'b0, 8'hFB);
    // R4 R5 R6: shortest packet
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b0, 8'h00);
    put(1'b1, 1'b1, 8'hFD);
    // R7 R8 R9 inside one packet, then R6
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b0, 8'hFF);
    put(1'b1, 1'b1, 8'hFE);
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b1, 8'hBC);
    put(1'b0, 1'b0, 8'h77);
    put(1'b1, 1'b0, 8'h3C);
    put(1'b1, 1'b1, 8'hFD);
    // R2: sync loss mid packet abandons it; data after resync stays idle (R3)
    put(1'b1, 1'b1, 8'hFB);
    put(1'b1, 1'b0, 8'h12);
    sync_ok = 1'b0;
    put(1'b1, 1'b0, 8'h34);
    sync_ok = 1'b1;
    put(1'b1, 1'b0, 8'h56);
    // R1: reset mid packet closes it
    put(1'b1, 1'b1, 8'hFB);
    rst_n = 1'b0;
    put(1'b1, 1'b0, 8'h9A);
    rst_n = 1'b1;
    put(1'b1, 1'b0, 8'hBC);
    // Random traffic
    for (int p = 0; p < 400; p++) rand_packet();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule